// File: doc/BRIEF.md
# Debug Boundary Register with Breakpoint and Trace

This block is a boundary-scan data register that keeps its ordinary scan duties and adds two board-debug functions. Its two storage stages, the rising-edge capture stage and the falling-edge update stage, both `W` bits wide, are reused. In breakpoint mode they hold the operands of a pin comparator. In trace mode they form a two-deep record of consecutive pin vectors. The TAP controller sits outside the block and supplies one-hot state strobes and instruction selects. A 3-bit control register, reached through its own select, picks the comparison type and the trace sequencing.

In breakpoint mode, every cell adds its own term to a ripple chain that starts at the cascade input `cdi` and ends at `cdo`. Devices can therefore be chained, and the last `cdo` can stop the functional clock. In trace mode, a small state machine on the falling edge decides when the pins are recorded. It can record freely, stop when `cdi` rises, or record the two vectors from the trigger cycle onward. The recorded pair is read out by shifting: the capture vector comes out first, then Exit2-DR moves the update vector into the capture stage for a second shift.

Top module: `dbg_bscan_trig`

## Requirements
- R1: With no select active, Capture-DR loads the pins into the capture stage. Shift-DR shifts it one place toward `tdo`, with `tdo` equal to capture bit 0 and `tdi` entering at bit W-1. Update-DR copies the capture stage into the update stage on the falling edge.
- R2: With `sel_ctrl` high, Shift-DR shifts a 3-bit control register (bit 0 leaves first, `tdi` enters at bit 2) and Update-DR applies it. Bit 0 selects the comparison: 0 is vector with mask, 1 is range. Bits [2:1] select the trace sequencing: 00 free-running, 01 until-condition, 10 after-condition, 11 behaves as free-running. The boundary stages are untouched while `sel_ctrl` is high.
- R3: With `sel_break` high, Exit2-DR copies the capture stage into the update stage on the falling edge, and Capture-DR leaves the capture stage unchanged. Operands are loaded by shifting the update operand, passing Exit2-DR, then shifting the capture operand.
- R4: In vector mode, `cdo` is 1 exactly when `in_idle`, `sel_break` and `cdi` are high and every pin whose update-stage (mask) bit is 0 equals the matching capture-stage (expected) bit. Pins whose mask bit is 1 always pass.
- R5: In range mode, `cdo` is 1 exactly when `in_idle`, `sel_break` and `cdi` are high and capture ≤ pins ≤ update, taken as unsigned numbers with inclusive limits.
- R6: Outside Run-Test/Idle, `cdo` is 0.
- R7: Free-running trace: while idle with `sel_trace`, each rising edge samples the pins, and after leaving idle the capture stage holds the last sampled vector and the update stage the one before it.
- R8: Until-condition trace: a falling edge that sees `cdi` high ends the recording without a copy. The capture stage keeps the last vector sampled before that edge and the update stage the vector before that, and further pin changes are ignored.
- R9: After-condition trace: no recording while waiting. `cdo` follows `cdi` while waiting in idle. The falling edge that sees `cdi` high starts storage of two vectors on the next two rising edges, the first sampled with the trigger cycle's pins. The update stage ends with the first vector and the capture stage with the second.
- R10: With `sel_trace` high, Capture-DR leaves the capture stage unchanged, and a rising edge in Exit2-DR copies the update stage into the capture stage.
- R11: Leaving Run-Test/Idle or an `instr_load` pulse returns the trace machine to monitoring, so a new idle period records afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| in_idle | input | 1 | TAP is in Run-Test/Idle |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| exit2_dr | input | 1 | TAP is in Exit2-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| instr_load | input | 1 | One-cycle pulse when a new instruction takes effect |
| sel_ctrl | input | 1 | Control-register access instruction active |
| sel_break | input | 1 | Breakpoint detection instruction active |
| sel_trace | input | 1 | Trace instruction active |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| pins | input | W | Observed device pin vector |
| cdi | input | 1 | Cascade condition input / external trigger |
| cdo | output | 1 | Condition detected output |

## Verification
The bench targets the exact edges of the trace sequences. In until mode, a copy on the stopping falling edge would leave both stages equal. In after mode, sampling one cycle late would record the vector after the trigger instead of the trigger cycle's own. The range comparator is driven at one below, exactly at and one above each limit, so an exclusive or off-by-one ripple shows up as a wrong `cdo`. A masked mismatch must still assert `cdo` and an unmasked one must not, and a lost re-arm after leaving idle would keep the old pair in the stages.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int CFG_W = 3;

  typedef enum logic [1:0] {
    TR_FREE  = 2'd0,
    TR_UNTIL = 2'd1,
    TR_AFTER = 2'd2,
    TR_RSVD  = 2'd3
  } trace_mode_e;

  typedef enum logic [1:0] {
    TS_MONITOR = 2'd0,
    TS_STORE1  = 2'd1,
    TS_STORE2  = 2'd2,
    TS_END     = 2'd3
  } trace_st_e;

  typedef struct packed {
    trace_mode_e tmode;      // bits [2:1]
    logic        range_sel;  // bit 0
  } cfg_t;
endpackage

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
  import dbr_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic sel,
  input  logic shift_en,
  input  logic update_en,
  input  logic tdi,
  output logic so,
  output cfg_t cfg
);
  logic [CFG_W-1:0] sh_q, sh_d, cfg_q, cfg_d;

  always_comb begin
    sh_d  = sh_q;
    cfg_d = cfg_q;
    if (sel && shift_en)  sh_d  = {tdi, sh_q[CFG_W-1:1]};
    if (sel && update_en) cfg_d = sh_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cfg_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cfg_q <= cfg_d;
    end
  end

  assign so  = sh_q[0];
  assign cfg = cfg_t'(cfg_q);
endmodule

// File: rtl/dbr_cond_chain.sv
module dbr_cond_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] pins,
  input  logic [W-1:0] cap,
  input  logic [W-1:0] upd,
  input  logic         cdi,
  input  logic         range_sel,
  output logic         hit
);
  // vector chain ripples from cell 0 (cdi) upward
  logic [W:0] vec_c;
  // range chains ripple from the most significant cell downward
  logic [W:0] lo_gt, lo_eq, hi_lt, hi_eq;

  assign vec_c[0] = cdi;
  assign lo_gt[W] = 1'b0;
  assign lo_eq[W] = 1'b1;
  assign hi_lt[W] = 1'b0;
  assign hi_eq[W] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign vec_c[i+1] = vec_c[i] & (upd[i] | ~(pins[i] ^ cap[i]));
    assign lo_gt[i]   = lo_gt[i+1] | (lo_eq[i+1] & pins[i] & ~cap[i]);
    assign lo_eq[i]   = lo_eq[i+1] & ~(pins[i] ^ cap[i]);
    assign hi_lt[i]   = hi_lt[i+1] | (hi_eq[i+1] & ~pins[i] & upd[i]);
    assign hi_eq[i]   = hi_eq[i+1] & ~(pins[i] ^ upd[i]);
  end

  logic rng_ok;
  assign rng_ok = cdi & (lo_gt[0] | lo_eq[0]) & (hi_lt[0] | hi_eq[0]);
  assign hit    = range_sel ? rng_ok : vec_c[W];
endmodule

// File: rtl/dbr_trace_fsm.sv
module dbr_trace_fsm
  import dbr_pkg::*;
(
  input  logic        tck,
  input  logic        rst_n,
  input  logic        in_idle,
  input  logic        sel_trace,
  input  logic        instr_load,
  input  logic        cdi,
  input  trace_mode_e tmode,
  output trace_st_e   state,
  output logic        rec_cap,
  output logic        rec_upd,
  output logic        trig
);
  trace_st_e st_q, st_d;
  logic arm, waits, stop_now;

  assign arm      = in_idle & sel_trace & ~instr_load;
  assign waits    = (tmode == TR_AFTER);
  assign stop_now = (tmode == TR_UNTIL) & cdi;

  always_comb begin
    st_d = st_q;
    if (!arm) st_d = TS_MONITOR;
    else begin
      unique case (st_q)
        TS_MONITOR: begin
          if (stop_now)         st_d = TS_END;
          else if (waits && cdi) st_d = TS_STORE1;
        end
        TS_STORE1: st_d = TS_STORE2;
        TS_STORE2: st_d = TS_END;
        TS_END:    st_d = TS_END;
      endcase
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) st_q <= TS_MONITOR;
    else        st_q <= st_d;
  end

  assign rec_cap = arm & ((st_q == TS_STORE1) | (st_q == TS_STORE2) |
                          ((st_q == TS_MONITOR) & ~waits));
  assign rec_upd = arm & ((st_q == TS_STORE1) |
                          ((st_q == TS_MONITOR) & ~waits & ~stop_now));
  assign trig    = arm & (st_q == TS_MONITOR) & waits & cdi;
  assign state   = st_q;
endmodule

// File: rtl/dbg_bscan_trig.sv
module dbg_bscan_trig
  import dbr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         in_idle,
  input  logic         capture_dr,
  input  logic         shift_dr,
  input  logic         exit2_dr,
  input  logic         update_dr,
  input  logic         instr_load,
  input  logic         sel_ctrl,
  input  logic         sel_break,
  input  logic         sel_trace,
  input  logic         tdi,
  output logic         tdo,
  input  logic [W-1:0] pins,
  input  logic         cdi,
  output logic         cdo
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  cfg_t      cfg;
  logic      ctrl_so;
  trace_st_e trace_st;
  logic      rec_cap, rec_upd, trig, hit;
  logic      dbg_sel;
  logic [W-1:0] cap_q, cap_d, upd_q, upd_d;

  assign dbg_sel = sel_break | sel_trace;

  dbr_ctrl u_ctrl (
    .tck(tck), .rst_n(rst_n), .sel(sel_ctrl), .shift_en(shift_dr),
    .update_en(update_dr), .tdi(tdi), .so(ctrl_so), .cfg(cfg)
  );

  dbr_trace_fsm u_fsm (
    .tck(tck), .rst_n(rst_n), .in_idle(in_idle), .sel_trace(sel_trace),
    .instr_load(instr_load), .cdi(cdi), .tmode(cfg.tmode),
    .state(trace_st), .rec_cap(rec_cap), .rec_upd(rec_upd), .trig(trig)
  );

  dbr_cond_chain #(.W(W)) u_chain (
    .pins(pins), .cap(cap_q), .upd(upd_q), .cdi(cdi),
    .range_sel(cfg.range_sel), .hit(hit)
  );

  // capture stage: rising edge
  always_comb begin
    cap_d = cap_q;
    if (sel_ctrl)                     cap_d = cap_q;
    else if (shift_dr)                cap_d = {tdi, cap_q[W-1:1]};
    else if (capture_dr && !dbg_sel)  cap_d = pins;
    else if (exit2_dr && sel_trace)   cap_d = upd_q;
    else if (rec_cap)                 cap_d = pins;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  // update stage: falling edge
  always_comb begin
    upd_d = upd_q;
    if (update_dr && !dbg_sel && !sel_ctrl) upd_d = cap_q;
    else if (exit2_dr && sel_break)         upd_d = cap_q;
    else if (rec_upd)                       upd_d = cap_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) upd_q <= '0;
    else        upd_q <= upd_d;
  end

  assign tdo = sel_ctrl ? ctrl_so : cap_q[0];
  assign cdo = (in_idle & sel_break & hit) | trig;
endmodule

// File: rtl/dbr_chk.sv
module dbr_chk
  import dbr_pkg::*;
#(
  parameter int W = 8
) (
  input logic         tck,
  input logic         rst_n,
  input logic         in_idle,
  input logic         capture_dr,
  input logic         shift_dr,
  input logic         exit2_dr,
  input logic         instr_load,
  input logic         sel_break,
  input logic         sel_trace,
  input logic         cdi,
  input logic         cdo,
  input logic [W-1:0] pins,
  input logic [W-1:0] cap_q,
  input logic [W-1:0] upd_q,
  input logic         range_sel,
  input logic [1:0]   st
);
  AST_CDO_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
    !in_idle |-> !cdo); // R6

  AST_VEC_MATCH: assert property (@(posedge tck) disable iff (!rst_n)
    (in_idle && sel_break && !sel_trace && !range_sel && cdo)
      |-> (cdi && (((pins ^ cap_q) & ~upd_q) == '0))); // R4

  AST_RANGE_IN: assert property (@(posedge tck) disable iff (!rst_n)
    (in_idle && sel_break && !sel_trace && range_sel && cdo)
      |-> (cdi && pins >= cap_q && pins <= upd_q)); // R5

  AST_CAPDR_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    ((sel_break || sel_trace) && capture_dr && !shift_dr && !exit2_dr && !in_idle)
      |=> $stable(cap_q)); // R10

  AST_LEAVE_MON: assert property (@(negedge tck) disable iff (!rst_n)
    (!in_idle || instr_load) |=> (st == TS_MONITOR)); // R11

  AST_STORE_SEQ: assert property (@(negedge tck) disable iff (!rst_n)
    (in_idle && sel_trace && !instr_load && st == TS_STORE1)
      |=> (st == TS_STORE2)); // R9

  AST_END_STICKY: assert property (@(negedge tck) disable iff (!rst_n)
    (in_idle && sel_trace && !instr_load && st == TS_END)
      |=> (st == TS_END)); // R8
endmodule

bind dbg_bscan_trig dbr_chk #(.W(W)) u_chk (
  .tck(tck), .rst_n(rst_n), .in_idle(in_idle), .capture_dr(capture_dr),
  .shift_dr(shift_dr), .exit2_dr(exit2_dr), .instr_load(instr_load),
  .sel_break(sel_break), .sel_trace(sel_trace), .cdi(cdi), .cdo(cdo),
  .pins(pins), .cap_q(cap_q), .upd_q(upd_q), .range_sel(cfg.range_sel),
  .st(trace_st)
);

// File: tb/sim_dbg_bscan_trig.sv
module sim_dbg_bscan_trig;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic tck = 1'b0;
  logic trst_n, in_idle, capture_dr, shift_dr, exit2_dr, update_dr;
  logic instr_load, sel_ctrl, sel_break, sel_trace, tdi, cdi;
  logic [W-1:0] pins;
  logic tdo, cdo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  dbg_bscan_trig #(.W(W)) u0 (
    .tck(tck), .trst_n(trst_n), .in_idle(in_idle), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .exit2_dr(exit2_dr), .update_dr(update_dr),
    .instr_load(instr_load), .sel_ctrl(sel_ctrl), .sel_break(sel_break),
    .sel_trace(sel_trace), .tdi(tdi), .tdo(tdo), .pins(pins), .cdi(cdi),
    .cdo(cdo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge tck); #1;
  endtask

  task automatic pulse_cap();  capture_dr = 1; cyc(); capture_dr = 0; endtask
  task automatic pulse_upd();  update_dr  = 1; cyc(); update_dr  = 0; endtask
  task automatic pulse_ex2();  exit2_dr   = 1; cyc(); exit2_dr   = 0; endtask

  task automatic select(input logic c, input logic b, input logic t);
    sel_ctrl = c; sel_break = b; sel_trace = t; instr_load = 1;
    cyc();
    instr_load = 0;
  endtask

  task automatic shift_word(input logic [W-1:0] din, output logic [W-1:0] dout);
    for (int i = 0; i < W; i++) begin
      tdi = din[i]; shift_dr = 1; #1;
      dout[i] = tdo;
      @(posedge tck); #1;
    end
    shift_dr = 0; tdi = 0;
  endtask

  task automatic write_cfg(input logic [2:0] v);
    select(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tdi = v[i]; shift_dr = 1; cyc();
    end
    shift_dr = 0; tdi = 0;
    pulse_upd();
  endtask

  task automatic load_operands(input logic [W-1:0] cap_v, input logic [W-1:0] upd_v);
    logic [W-1:0] junk;
    select(1'b0, 1'b1, 1'b0);
    shift_word(upd_v, junk);
    pulse_ex2();
    shift_word(cap_v, junk);
  endtask

  task automatic probe(input string req, input logic [W-1:0] p, input logic c,
                       input logic idle, input logic exp);
    in_idle = idle; pins = p; cdi = c; #2;
    check(req, {31'd0, cdo}, {31'd0, exp});
    cyc();
  endtask

  task automatic rec(input logic [W-1:0] p, input logic c);
    in_idle = 1; pins = p; cdi = c; cyc();
  endtask

  task automatic read_pair(input string req, input logic [W-1:0] exp_cap,
                           input logic [W-1:0] exp_upd);
    logic [W-1:0] got;
    in_idle = 0; cdi = 0; cyc();
    pulse_cap();                       // R10: must not disturb capture stage
    shift_word('0, got);
    check({req, " capture"}, {24'd0, got}, {24'd0, exp_cap});
    pulse_ex2();
    shift_word('0, got);
    check({req, " update"}, {24'd0, got}, {24'd0, exp_upd});
  endtask

  task automatic t_reset();
    trst_n = 0; in_idle = 0; capture_dr = 0; shift_dr = 0; exit2_dr = 0;
    update_dr = 0; instr_load = 0; sel_ctrl = 0; sel_break = 0; sel_trace = 0;
    tdi = 0; cdi = 0; pins = '0;
    repeat (3) cyc();
    trst_n = 1;
    repeat (3) cyc();
    check("reset tdo", {31'd0, tdo}, 32'd0);
    check("reset cdo R6", {31'd0, cdo}, 32'd0);
  endtask

  task automatic t_normal_r1();
    logic [W-1:0] got;
    pins = 8'hA5;
    pulse_cap();
    shift_word(8'h3C, got);
    check("R1 capture/shift", {24'd0, got}, 32'h0A5);
    pulse_upd();
    select(1'b0, 1'b0, 1'b1);
    pulse_ex2();
    shift_word('0, got);
    check("R1 update copy", {24'd0, got}, 32'h03C);
  endtask

  task automatic t_vector();
    write_cfg(3'b000);                 // R2: vector mode
    load_operands(8'hA0, 8'h0F);       // R3: expected A0, mask 0F
    probe("R4 full match", 8'hA0, 1, 1, 1);
    probe("R4 masked diff", 8'hA7, 1, 1, 1);
    probe("R4 unmasked diff", 8'hB0, 1, 1, 0);
    probe("R4 cdi low", 8'hA0, 0, 1, 0);
    probe("R6 not idle", 8'hA0, 1, 0, 0);
  endtask

  task automatic t_range();
    write_cfg(3'b001);                 // R2: range mode
    load_operands(8'h20, 8'h60);       // R3: A=20 low, B=60 high
    probe("R5 below A", 8'h1F, 1, 1, 0);
    probe("R5 equal A", 8'h20, 1, 1, 1);
    probe("R5 inside", 8'h45, 1, 1, 1);
    probe("R5 equal B", 8'h60, 1, 1, 1);
    probe("R5 above B", 8'h61, 1, 1, 0);
    probe("R5 cdi low", 8'h45, 0, 1, 0);
    in_idle = 0; cdi = 0; cyc();
  endtask

  task automatic t_free_r7();
    write_cfg(3'b000);
    select(1'b0, 1'b0, 1'b1);
    rec(8'h11, 0); rec(8'h22, 0); rec(8'h33, 0); rec(8'h44, 0);
    read_pair("R7 free", 8'h44, 8'h33);
  endtask

  task automatic t_until_r8();
    write_cfg(3'b010);
    select(1'b0, 1'b0, 1'b1);
    rec(8'h51, 0); rec(8'h52, 0); rec(8'h53, 0);
    rec(8'h54, 1); rec(8'h55, 0); rec(8'h56, 0);
    read_pair("R8 until", 8'h53, 8'h52);
    // R11: leaving idle re-arms recording
    rec(8'h61, 0); rec(8'h62, 0); rec(8'h63, 0);
    read_pair("R11 rearm", 8'h63, 8'h62);
  endtask

  task automatic t_after_r9();
    write_cfg(3'b100);
    select(1'b0, 1'b0, 1'b1);
    rec(8'h71, 0); rec(8'h72, 0);
    in_idle = 1; pins = 8'h73; cdi = 1; #2;
    check("R9 cdo on trigger", {31'd0, cdo}, 32'd1);
    cyc();
    in_idle = 1; pins = 8'h74; cdi = 0; #2;
    check("R9 cdo after trigger", {31'd0, cdo}, 32'd0);
    cyc();
    rec(8'h75, 0); rec(8'h76, 0);
    read_pair("R9 after", 8'h74, 8'h73);
  endtask

  initial begin
    t_reset();
    t_normal_r1();
    t_vector();
    t_range();
    t_free_r7();
    t_until_r8();
    t_after_r9();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule